// File: doc/BRIEF.md
# Two-Wire Serial Register Port with Framing Recovery

This block is the peripheral end of a synchronous serial link that uses one host-driven clock line and one shared, bidirectional data line. Each transaction opens with a header byte: a direction bit followed by a seven-bit register address. After a write header the port shifts in one data byte and stores it. After a read header the port takes over the data line on the next falling clock edge and shifts the addressed register out, most significant bit first. It then lets go of the line.

The host's serial clock and data are brought into the system clock domain through a synchronizer, and both edges are detected there. The port does not filter clock edges. A stray rising edge, such as the one the host causes when it first drives the clock line high, is counted as a real bit and puts the port out of step with the host. The port can get back in step in two ways. An inactivity watchdog throws away a partial frame when the clock line has been quiet for a set number of system clock cycles. A power-down pulse input clears the framing logic immediately. Register 0 is a fixed identification register. Every other address is a plain read/write byte.

Top module: `sio_regport`

## Requirements
- R1: The first bit sampled on a rising serial clock edge of a frame is the direction bit: 1 selects a write and 0 selects a read.
- R2: The seven address bits follow the direction bit, MSB first. A write then takes eight data bits, MSB first, and the byte is committed after its eighth rising edge.
- R3: After a read header, the port sets `sdio_oe` and drives the data MSB on the first falling serial clock edge. Each later falling edge presents the next lower bit.
- R4: Reading address 0x00 returns the identification value ID_VALUE (default 0x02).
- R5: Writes to address 0x00 are ignored. Every other address returns the last value written to it.
- R6: When the serial clock line shows no edge for WDOG_CYCLES system clock cycles, the partial frame is discarded and `sdio_oe` is cleared. The next rising edge is then taken as a direction bit.
- R7: While `pwrdn` is high, the framing logic is held cleared and `sdio_oe` is low. The first rising edge after the pulse is a direction bit.
- R8: A stray rising edge is counted as a frame bit. For example, one extra rising edge ahead of a read header makes the port drive the line one bit time early.
- R9: After the rising edge that samples the eighth read data bit, the port clears `sdio_oe` and returns to waiting for a header.
- R10: After reset, `sdio_oe` is low, the port waits for a header, and registers 0x01 to 0x7F read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| sdio_in | input | 1 | Level seen on the shared data line |
| pwrdn | input | 1 | Power-down pulse, active high, synchronous to clk; clears framing |
| sdio_out | output | 1 | Data the port drives while reading out |
| sdio_oe | output | 1 | Drive enable for the data line |

## Verification
The bench goes after framing slips. It applies one stray rising edge before a read header. It abandons frames partway through the header and partway through the read-out, then recovers with the watchdog or with a power-down pulse. A port that filtered the stray edge would not drive early. A port without working recovery would stay shifted by a bit and read back a wrong identification value. The bench also writes 0xFF to the identification address, checks that the line is driven exactly from the first falling edge after the header, and checks that the drive is released after the eighth data bit. A design that wrote register 0, turned the line around at the wrong edge or held the line would fail these checks.

// File: rtl/sio_pkg.sv
// Shared types for the serial register port.
// Assumes: one header byte (direction plus address) precedes each data byte.
package sio_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,   // collecting direction and address bits
        ST_WDAT = 2'd1,   // collecting write data bits
        ST_TURN = 2'd2,   // header done, waiting for falling edge to drive
        ST_RDAT = 2'd3    // shifting read data out
    } frame_state_e;
endpackage

// File: rtl/sio_edge_sync.sv
// Brings the serial clock and data line into the clk domain and flags edges.
// Assumes: STAGES >= 2. The chain is deliberately not reset, so the level of
// the serial clock when reset is released is never seen as an edge.
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic sclk,
    input  logic sdio,
    output logic rise,
    output logic fall,
    output logic din
);
    logic [STAGES-1:0][1:0] chain;
    logic                   sclk_prev;

    // Shift {sclk, sdio} through the synchronizer chain together.
    always_ff @(posedge clk) begin
        chain     <= {chain[STAGES-2:0], {sclk, sdio}};
        sclk_prev <= chain[STAGES-1][1];
    end

    // Edge pulses and data sampled at the same stage as the clock.
    always_comb begin
        rise = chain[STAGES-1][1] & ~sclk_prev;
        fall = ~chain[STAGES-1][1] & sclk_prev;
        din  = chain[STAGES-1][0];
    end
endmodule

// File: rtl/sio_watchdog.sv
// Inactivity timer: pulses timeout once after LIMIT cycles with no serial edge.
// Assumes: activity is a one-cycle pulse per detected edge; restart clears it.
module sio_watchdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    input  logic restart,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count idle cycles, saturating at LIMIT; any edge restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || activity || restart)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    // Single pulse on the cycle the count reaches its limit.
    assign timeout = (cnt == CW'(LIMIT - 1)) && !activity && !restart;

    assert_wd_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));
endmodule

// File: rtl/sio_regfile.sv
// Byte register file: entry 0 is a constant identification value, the
// rest are read/write. Assumes the caller never writes entry 0.
module sio_regfile #(
    parameter int          ADDR_W   = 7,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  ID_VALUE = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NUM_REGS = 2 ** ADDR_W;
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_id
            // Identification entry is fixed.
            assign regs[i] = DATA_W'(ID_VALUE);
        end else begin : g_rw
            // Plain storage entry, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (wr_en && addr == ADDR_W'(i))
                    regs[i] <= wr_data;
            end
        end
    end

    assign rd_data = regs[addr];

    assert_no_id_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> addr != '0);
endmodule

// File: rtl/sio_regport.sv
// Serial register port: frames direction, address and data on the serial
// clock, turns the data line around for reads, and recovers framing via the
// inactivity watchdog or the power-down pulse.
// Assumes: pwrdn is synchronous to clk; sclk half-periods exceed the
// synchronizer latency by a few clk cycles.
module sio_regport #(
    parameter int         ADDR_W      = 7,
    parameter int         DATA_W      = 8,
    parameter logic [7:0] ID_VALUE    = 8'h02,
    parameter int         WDOG_CYCLES = 1024,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdio_in,
    input  logic pwrdn,
    output logic sdio_out,
    output logic sdio_oe
);
    import sio_pkg::*;

    localparam int HDR_LEN = ADDR_W + 1;
    localparam int MAXLEN  = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
    localparam int CNT_W   = $clog2(MAXLEN);

    logic               s_rise, s_fall, s_din, wd_timeout, clear;
    frame_state_e       state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [HDR_LEN-2:0] hdr_sh;
    logic [HDR_LEN-1:0] hdr_next;
    logic [DATA_W-2:0]  wdat_sh;
    logic [DATA_W-1:0]  wr_data, rd_data, rdat_sh;
    logic [ADDR_W-1:0]  addr_q;
    logic               wr_en;

    sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .sclk(sclk), .sdio(sdio_in),
        .rise(s_rise), .fall(s_fall), .din(s_din)
    );

    sio_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .activity(s_rise | s_fall),
        .restart(pwrdn), .timeout(wd_timeout)
    );

    sio_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr_q),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    // Either recovery source discards the frame in progress.
    assign clear    = pwrdn | wd_timeout;
    // Header and write byte as they stand after the bit now being sampled.
    assign hdr_next = {hdr_sh, s_din};
    assign wr_data  = {wdat_sh, s_din};
    // Commit a write on its last data bit, except to the identification entry.
    assign wr_en    = (state == ST_WDAT) && s_rise && !clear &&
                      (bit_cnt == CNT_W'(DATA_W - 1)) && (addr_q != '0);
    assign sdio_out = rdat_sh[DATA_W-1];

    // Frame sequencer: header capture, write shift-in, turnaround, read shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state   <= ST_HDR;
            bit_cnt <= '0;
            hdr_sh  <= '0;
            wdat_sh <= '0;
            rdat_sh <= '0;
            sdio_oe <= 1'b0;
            if (!rst_n) addr_q <= '0;
        end else begin
            case (state)
                ST_HDR: if (s_rise) begin
                    hdr_sh <= hdr_next[HDR_LEN-2:0];
                    if (bit_cnt == CNT_W'(HDR_LEN - 1)) begin
                        bit_cnt <= '0;
                        addr_q  <= hdr_next[ADDR_W-1:0];
                        state   <= hdr_next[HDR_LEN-1] ? ST_WDAT : ST_TURN;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_WDAT: if (s_rise) begin
                    wdat_sh <= wr_data[DATA_W-2:0];
                    if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                        bit_cnt <= '0;
                        state   <= ST_HDR;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TURN: if (s_fall) begin
                    rdat_sh <= rd_data;
                    sdio_oe <= 1'b1;
                    bit_cnt <= '0;
                    state   <= ST_RDAT;
                end
                ST_RDAT: begin
                    if (s_rise) begin
                        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                            bit_cnt <= '0;
                            sdio_oe <= 1'b0;
                            state   <= ST_HDR;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else if (s_fall) begin
                        rdat_sh <= {rdat_sh[DATA_W-2:0], 1'b0};
                    end
                end
                default: state <= ST_HDR;
            endcase
        end
    end

    assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(s_fall));
    assert_release_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> $past(s_rise || clear));
    assert_pwrdn_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> (!sdio_oe && state == ST_HDR && bit_cnt == '0));
    assert_timeout_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> (!sdio_oe && state == ST_HDR));
    assert_oe_only_reading_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> state == ST_RDAT);
endmodule

// File: tb/sio_regport_tb.sv
`timescale 1ns/1ps
module sio_regport_tb;
    localparam int HALF = 8;     // clk cycles per serial clock phase
    localparam int WDOG = 64;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, host_d = 1'b0, pwrdn = 1'b0;
    logic sdio_out, sdio_oe;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    sio_regport #(.WDOG_CYCLES(WDOG)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdio_in(host_d),
        .pwrdn(pwrdn), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One host-driven bit: data set on the falling phase, sampled on the rise.
    task automatic put_bit(input logic b);
        @(negedge clk); sclk = 1'b0; host_d = b; wait_clk(HALF);
        sclk = 1'b1; wait_clk(HALF);
    endtask

    task automatic put_hdr(input logic dir, input logic [6:0] a);
        put_bit(dir);
        for (int i = 6; i >= 0; i--) put_bit(a[i]);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
        put_hdr(1'b1, a);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
    endtask

    // Read a byte, checking the drive enable on every data bit and after.
    task automatic read_reg(input logic [6:0] a, output logic [7:0] d, input string req);
        put_hdr(1'b0, a);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; wait_clk(HALF);
            if (!sdio_oe) begin
                n_chk++; n_fail++;
                $display("FAIL R3 (%s): actual oe=0 expected oe=1 at bit %0d", req, i);
            end
            d[i] = sdio_out;
            sclk = 1'b1; wait_clk(HALF);
        end
        check("R9 release after read", {31'd0, sdio_oe}, 32'd0);
    endtask

    task automatic pulse_pwrdn;
        @(negedge clk); pwrdn = 1'b1; wait_clk(2); pwrdn = 1'b0; wait_clk(2);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R10 oe after reset", {31'd0, sdio_oe}, 32'd0);
        // R8: stray rise while host first drives clock high, then a read header.
        @(negedge clk); host_d = 1'b0; sclk = 1'b1; wait_clk(HALF);
        for (int i = 0; i < 7; i++) put_bit(1'b0);
        @(negedge clk); sclk = 1'b0; wait_clk(HALF);
        check("R8 stray edge counted, early drive", {31'd0, sdio_oe}, 32'd1);
        sclk = 1'b1; wait_clk(HALF);
        pulse_pwrdn();
        check("R7 oe cleared by pwrdn", {31'd0, sdio_oe}, 32'd0);
        read_reg(7'h00, d, "R4");
        check("R4 id after pwrdn resync", {24'd0, d}, 32'h02);
        read_reg(7'h05, d, "R10");
        check("R10 register cleared by reset", {24'd0, d}, 32'h00);
    endtask

    task automatic t_write_readback;
        logic [7:0] d;
        write_reg(7'h13, 8'h5A);
        write_reg(7'h7F, 8'hA5);
        write_reg(7'h01, 8'h81);
        read_reg(7'h13, d, "R5"); check("R5 R2 readback 0x13", {24'd0, d}, 32'h5A);
        read_reg(7'h7F, d, "R5"); check("R5 R2 readback 0x7F", {24'd0, d}, 32'hA5);
        read_reg(7'h01, d, "R5"); check("R5 R1 readback 0x01", {24'd0, d}, 32'h81);
    endtask

    task automatic t_id_write_ignored;
        logic [7:0] d;
        write_reg(7'h00, 8'hFF);
        read_reg(7'h00, d, "R5"); check("R5 id write ignored", {24'd0, d}, 32'h02);
    endtask

    task automatic t_turnaround;
        // R3: no drive during the header's last high phase; drive after next fall.
        put_hdr(1'b0, 7'h13);
        check("R3 no drive before fall", {31'd0, sdio_oe}, 32'd0);
        @(negedge clk); sclk = 1'b0; wait_clk(HALF);
        check("R3 drive after first fall", {31'd0, sdio_oe}, 32'd1);
        check("R3 MSB first", {31'd0, sdio_out}, 32'd0);
        sclk = 1'b1; wait_clk(HALF);
        // R6: abandon read mid-byte; watchdog must release the line.
        wait_clk(WDOG + 20);
        check("R6 watchdog releases line", {31'd0, sdio_oe}, 32'd0);
    endtask

    task automatic t_watchdog_hdr;
        logic [7:0] d;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        wait_clk(WDOG + 20);
        read_reg(7'h00, d, "R6");
        check("R6 header discarded by watchdog", {24'd0, d}, 32'h02);
    endtask

    task automatic t_pwrdn_mid;
        logic [7:0] d;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        pulse_pwrdn();
        read_reg(7'h7F, d, "R7");
        check("R7 partial write dropped", {24'd0, d}, 32'hA5);
    endtask

    initial begin
        fork
            begin
                wait_clk(10); rst_n = 1'b1; wait_clk(4);
                t_reset();
                t_write_readback();
                t_id_write_ignored();
                t_turnaround();
                t_watchdog_hdr();
                t_pwrdn_mid();
                done = 1'b1;
            end
            begin
                wait_clk(150000);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule